// File: doc/BRIEF.md
# Dual-Register Self-Test Sequencer

This controller runs a two-phase built-in self-test on a pair of logic-observer registers. Call them register A and register B. They sit on either side of two combinational networks. In each phase one register supplies pseudorandom patterns and the other compresses the responses into a signature. The controller serially loads a non-zero seed into the generating register and clears the compressing register. It then lets both run for a programmed number of clocks. After that it shifts the signature back, compares it against a known-good value, and swaps the two roles for the second phase.

The controller drives a 2-bit mode code to each register and one serial data line into whichever register is shifting. It also drives a shift enable. It receives the serial stream coming back from the shifting register. When `start` is accepted, the controller captures the seeds, the run length and the two expected signatures. It ignores all of these inputs after that point until the next accepted start. At the end it raises `done` together with exactly one of `pass` and `fail`. All three flags stay held until the next accepted start.

Top module: `bist_pair_seq`

## Requirements
- R1: In reset, and while idle, both mode outputs read 2'b11 (normal), `scan_en` and `scan_out` are 0, and `done`, `pass`, `fail` and `cfg_err` are 0 after reset. Mode codes: 2'b11 normal, 2'b00 shift, 2'b10 signature/generate, 2'b01 clear.
- R2: The first clock after an accepted start begins phase 1. Phase 1 lasts exactly W clocks, with `mode_a`=00, `mode_b`=01 and `scan_en`=1. `scan_out` carries `seed_a` most significant bit first.
- R3: Phase 2 follows phase 1 and lasts exactly `run_cycles` clocks. Both modes are 2'b10 and `scan_en` is 0.
- R4: Phase 3 follows and lasts W clocks, with `mode_a`=01, `mode_b`=00 and `scan_en`=1. `scan_out` carries `seed_b` most significant bit first. The controller samples `scan_in` on each of these clocks and assembles a word MSB first, to be compared with `sig_exp_b`.
- R5: Phase 4 follows and lasts exactly `run_cycles` clocks. Both modes are 2'b10 and `scan_en` is 0.
- R6: Phase 5 follows and lasts W clocks, with `mode_a`=00, `mode_b`=11, `scan_en`=1 and `scan_out`=0. The controller samples `scan_in` MSB first for comparison with `sig_exp_a`.
- R7: `done` rises on the clock after the last phase-5 clock. `pass` is 1 only if both assembled words matched; otherwise `fail` is 1. Exactly one of them is set while `done` is high. `done`, `pass` and `fail` hold until the next accepted start, which clears them.
- R8: A start with `seed_a`=0, `seed_b`=0 or `run_cycles`=0 runs no phase. On the next clock `done`, `fail` and `cfg_err` read 1 and the modes remain 2'b11.
- R9: A `start` pulse during phases 1 to 5 is ignored. Input changes after an accepted start do not alter the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test when idle |
| run_cycles | input | CW | Clocks per run phase |
| seed_a | input | W | Seed loaded into register A |
| seed_b | input | W | Seed loaded into register B |
| sig_exp_a | input | W | Known-good signature of register A |
| sig_exp_b | input | W | Known-good signature of register B |
| scan_in | input | 1 | Serial data returned by the shifting register |
| mode_a | output | 2 | Mode code for register A |
| mode_b | output | 2 | Mode code for register B |
| scan_en | output | 1 | Serial shift in progress |
| scan_out | output | 1 | Serial data to the shifting register |
| done | output | 1 | Test finished |
| pass | output | 1 | Both signatures matched |
| fail | output | 1 | A signature mismatched or configuration rejected |
| cfg_err | output | 1 | Configuration rejected |

## Verification
A corrupted phase or counter state appears at the mode outputs within one clock. Either a phase is lengthened or shortened by a clock, or the wrong register is placed in shift or clear. The bench checks every clock of every phase against a schedule computed from W and the run length, so a count that is off by one is caught at the phase boundary where it occurs. A corrupted capture or comparison shows only when `done` rises, as a swapped `pass`/`fail`. For that reason the bench includes vectors that mismatch in one phase only, one for each phase.

// File: rtl/bist_pair_seq.sv
module bist_pair_seq #(
  parameter int W  = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] run_cycles,
  input  logic [W-1:0]  seed_a,
  input  logic [W-1:0]  seed_b,
  input  logic [W-1:0]  sig_exp_a,
  input  logic [W-1:0]  sig_exp_b,
  input  logic          scan_in,
  output logic [1:0]    mode_a,
  output logic [1:0]    mode_b,
  output logic          scan_en,
  output logic          scan_out,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          cfg_err
);
  localparam int BW = $clog2(W);
  localparam int KW = (CW > BW + 1) ? CW : BW + 1;
  localparam logic [1:0] M_NORM = 2'b11, M_SHIFT = 2'b00, M_SIG = 2'b10, M_CLR = 2'b01;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RUN1, S_SWAP, S_RUN2, S_DRAIN} st_t;

  st_t           st;
  logic [KW-1:0] cnt;
  logic [CW-1:0] n_q;
  logic [W-1:0]  sh, seed_b_q, exp_a_q, exp_b_q, cap;
  logic          bad_b;

  wire [KW-1:0] run_end   = KW'(n_q) - KW'(1);
  wire          last_scan = (cnt == KW'(W - 1));
  wire          last_run  = (cnt == run_end);
  wire          cfg_bad   = (seed_a == '0) || (seed_b == '0) || (run_cycles == '0);
  wire [W-1:0]  cap_nx    = {cap[W-2:0], scan_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      n_q <= '0;
      sh <= '0;
      seed_b_q <= '0;
      exp_a_q <= '0;
      exp_b_q <= '0;
      cap <= '0;
      bad_b <= 1'b0;
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pass <= 1'b0;
          cnt <= '0;
          if (cfg_bad) begin
            done <= 1'b1;
            fail <= 1'b1;
            cfg_err <= 1'b1;
          end else begin
            done <= 1'b0;
            fail <= 1'b0;
            cfg_err <= 1'b0;
            st <= S_LOAD;
            n_q <= run_cycles;
            sh <= seed_a;
            seed_b_q <= seed_b;
            exp_a_q <= sig_exp_a;
            exp_b_q <= sig_exp_b;
            bad_b <= 1'b0;
          end
        end
        S_LOAD: begin
          sh <= sh << 1;
          cnt <= last_scan ? '0 : cnt + KW'(1);
          if (last_scan) st <= S_RUN1;
        end
        S_RUN1: begin
          cnt <= last_run ? '0 : cnt + KW'(1);
          if (last_run) begin
            st <= S_SWAP;
            sh <= seed_b_q;
          end
        end
        S_SWAP: begin
          sh <= sh << 1;
          cap <= cap_nx;
          cnt <= last_scan ? '0 : cnt + KW'(1);
          if (last_scan) begin
            bad_b <= (cap_nx != exp_b_q);
            st <= S_RUN2;
          end
        end
        S_RUN2: begin
          cnt <= last_run ? '0 : cnt + KW'(1);
          if (last_run) st <= S_DRAIN;
        end
        S_DRAIN: begin
          cap <= cap_nx;
          cnt <= last_scan ? '0 : cnt + KW'(1);
          if (last_scan) begin
            st <= S_IDLE;
            done <= 1'b1;
            pass <= !bad_b && (cap_nx == exp_a_q);
            fail <= bad_b || (cap_nx != exp_a_q);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mode_a = M_NORM;
    mode_b = M_NORM;
    scan_en = 1'b0;
    scan_out = 1'b0;
    case (st)
      S_LOAD: begin
        mode_a = M_SHIFT;
        mode_b = M_CLR;
        scan_en = 1'b1;
        scan_out = sh[W-1];
      end
      S_RUN1, S_RUN2: begin
        mode_a = M_SIG;
        mode_b = M_SIG;
      end
      S_SWAP: begin
        mode_a = M_CLR;
        mode_b = M_SHIFT;
        scan_en = 1'b1;
        scan_out = sh[W-1];
      end
      S_DRAIN: begin
        mode_a = M_SHIFT;
        scan_en = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bist_pair_seq_chk.sv
module bist_pair_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_a,
  input logic [1:0] mode_b,
  input logic       scan_en,
  input logic       done,
  input logic       pass,
  input logic       fail,
  input logic       cfg_err
);
  // R7
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));
  // R7
  verdict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!pass && !fail));
  // R2
  one_shifter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> ((mode_a == 2'b00) != (mode_b == 2'b00)));
  // R3
  run_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == 2'b10) |-> (mode_b == 2'b10 && !scan_en));
  // R8
  cfg_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (done && fail));
  // R6
  done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !cfg_err) |-> ($past(mode_a) == 2'b00 && $past(mode_b) == 2'b11));
endmodule

bind bist_pair_seq bist_pair_seq_chk u_chk (.*);

// File: tb/bist_pair_seq_bench.sv
module bist_pair_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, scan_in = 1'b0;
  logic [15:0] run_cycles = '0;
  logic [7:0]  seed_a = '0, seed_b = '0, sig_exp_a = '0, sig_exp_b = '0;
  logic [1:0]  mode_a, mode_b;
  logic        scan_en, scan_out, done, pass, fail, cfg_err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bist_pair_seq #(.W(8), .CW(16)) u_bist_pair_seq (.*);

  typedef struct packed {
    logic [7:0] sa, sb;
    logic [15:0] n;
    logic [7:0] gb, ga, eb, ea;
    logic ok;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{sa:8'hA5, sb:8'h3C, n:16'd4, gb:8'h5A, ga:8'hC3, eb:8'h5A, ea:8'hC3, ok:1'b1},
    '{sa:8'h01, sb:8'h80, n:16'd1, gb:8'hFF, ga:8'h00, eb:8'hFF, ea:8'h01, ok:1'b0},
    '{sa:8'hFF, sb:8'h7E, n:16'd7, gb:8'h12, ga:8'h99, eb:8'h13, ea:8'h99, ok:1'b0},
    '{sa:8'h96, sb:8'h69, n:16'd2, gb:8'h00, ga:8'hFF, eb:8'h00, ea:8'hFF, ok:1'b1}
  };

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {mode_a, mode_b, scan_en, scan_out};
  endfunction

  task automatic run_test(input vec_t v, input bit poke);
    logic [5:0] e;
    @(negedge clk);
    seed_a = v.sa; seed_b = v.sb; run_cycles = v.n;
    sig_exp_a = v.ea; sig_exp_b = v.eb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !pass && !fail, "R7 clear on start", {done, pass, fail}, 0);
    for (int i = 0; i < 8; i++) begin
      e = {2'b00, 2'b01, 1'b1, v.sa[7-i]};
      chk(outs() == e, "R2 phase1", outs(), e);
      @(negedge clk);
    end
    for (int i = 0; i < int'(v.n); i++) begin
      if (poke && i == 0) begin start = 1'b1; seed_b = ~v.sb; run_cycles = 16'd1; end
      e = 6'b10_10_0_0;
      chk(outs() == e, "R3 phase2", outs(), e);
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      scan_in = v.gb[7-i];
      e = {2'b01, 2'b00, 1'b1, v.sb[7-i]};
      chk(outs() == e, poke ? "R9 phase3 after busy start" : "R4 phase3", outs(), e);
      @(negedge clk);
    end
    for (int i = 0; i < int'(v.n); i++) begin
      e = 6'b10_10_0_0;
      chk(outs() == e, "R5 phase4", outs(), e);
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      scan_in = v.ga[7-i];
      e = 6'b00_11_1_0;
      chk(outs() == e, "R6 phase5", outs(), e);
      chk(!done, "R6 done early", done, 0);
      @(negedge clk);
    end
    scan_in = 1'b0;
    chk(done && pass == v.ok && fail == !v.ok && !cfg_err, "R7 verdict",
        {done, pass, fail, cfg_err}, {1'b1, v.ok, !v.ok, 1'b0});
    repeat (3) @(negedge clk);
    chk(done && pass == v.ok && outs() == 6'b11_11_0_0, "R7 hold",
        {done, pass, outs()}, {1'b1, v.ok, 6'b11_11_0_0});
  endtask

  task automatic cfg_test(input logic [7:0] sa, input logic [7:0] sb, input logic [15:0] n);
    @(negedge clk);
    seed_a = sa; seed_b = sb; run_cycles = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && fail && cfg_err && !pass, "R8 flags", {done, fail, cfg_err, pass}, 4'b1110);
    chk(outs() == 6'b11_11_0_0, "R8 no phase", outs(), 6'b11_11_0_0);
    @(negedge clk);
    chk(outs() == 6'b11_11_0_0 && done, "R8 stays idle", {done, outs()}, {1'b1, 6'b11_11_0_0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(outs() == 6'b11_11_0_0, "R1 modes in reset", outs(), 6'b11_11_0_0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outs() == 6'b11_11_0_0 && {done, pass, fail, cfg_err} == 4'b0, "R1 idle",
        {done, pass, fail, cfg_err, outs()}, {4'b0, 6'b11_11_0_0});
    foreach (TBL[k]) run_test(TBL[k], 1'b0);
    cfg_test(8'h00, 8'h55, 16'd3);
    cfg_test(8'h55, 8'h00, 16'd3);
    cfg_test(8'h55, 8'hAA, 16'd0);
    run_test(TBL[0], 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule